// File: doc/BRIEF.md
# NAND Page Read Engine

This block models the read side of a small-page NAND memory as seen from the device. Bytes arrive on an 8-bit bus. A write strobe qualifies each byte, and the command-latch and address-latch levels decide whether that byte is a command or an address. A command selects one of three read areas. Area A is the first half of the main array, area B is the second half, and area C is the spare bytes. Three address bytes then name a column and a 16-bit row, and a page load begins. While the page load runs, the ready line stays low for a fixed number of cycles.

Once ready, each read strobe returns the next byte of the page. Output runs up to the end of the page, which is 528 bytes including the spare. A read strobe past the end of the page loads the next row and continues from the start column of the current area. This continues until the last page of a 32-page block, where the read stops. The read also stops when chip enable stays high for too long.

The array is a computed pattern, so the block needs no storage array.

Top module: `nand_read_engine`

## Requirements
- R1: Command bytes pick the area: 8'h00 selects A, 8'h01 selects B and 8'h50 selects C. 8'hFF resets: the pointer returns to A, any load or stream is abandoned, and ready goes high. After rst_n the pointer is A. Three address bytes follow a command: the column first, then the row low byte, then the row high byte.
- R2: A pointer set to A or C stays in force for every later read until another command changes it. A read may be started by address bytes alone.
- R3: A pointer set to B serves one read only. Once the third address byte of that read is taken, the pointer is A again.
- R4: The first byte index k depends on the area. In A it is the column. In B it is 256 plus the column. In C it is 512 plus column bits [3:0], and column bits [7:4] have no effect.
- R5: rdy falls at the edge that takes the third address byte. It stays low for exactly LOAD_CYC (8) cycles.
- R6: When ready, each read strobe returns byte k of the loaded row r, then advances k, up to k = 527. Byte k of row r is ((k[7:0] ^ {k[9:8],6'b0}) + r[7:0]) mod 256.
- R7: A read strobe after byte 527, with chip enable low, does three things. It returns the filler byte, loads row r+1 with a busy time of LOAD_CYC, and restarts k at the area base: 0 for A, 256 for B, 512 for C.
- R8: If row r[4:0] is 31, the strobe after byte 527 returns the filler and ends the read. Later strobes return the filler.
- R9: Chip enable held high for more than CE_HOLD (4) consecutive cycles ends a load or stream. Holding it for CE_HOLD cycles or fewer leaves the read intact.
- R10: While chip enable is high, read and write strobes are ignored and dout holds its value.
- R11: A read strobe while busy, or with no read in progress, returns the filler 8'h5A and does not move k.
- R12: After reset, rdy is 1 and dout is the filler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Byte on din is a command |
| ale | input | 1 | Byte on din is an address |
| we_p | input | 1 | One-cycle write strobe that latches din |
| din | input | 8 | Command or address byte |
| re_p | input | 1 | One-cycle read strobe |
| dout | output | 8 | Byte returned by the last read strobe |
| rdy | output | 1 | High when not loading a page |

## Verification
A read strobe can arrive on the same edge that ends the busy count. The load then completes on that edge, and the strobe is still treated as early. The bench counts the busy cycles after the third address byte and places a read strobe exactly on the final busy edge. It expects the filler on dout and rdy high afterwards. It then expects the start column's byte on the next strobe, which shows that k did not move. Chip-enable timeout and a stream in progress also meet. The bench holds chip enable high for exactly CE_HOLD cycles, with ignored strobes inside that window, and then for one cycle more. It judges each case by whether the next byte continues the stream or is the filler.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  typedef enum logic [1:0] {AREA_A = 2'd0, AREA_B = 2'd1, AREA_C = 2'd2} area_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LOAD = 2'd1, ST_STREAM = 2'd2} rd_state_e;

  localparam logic [7:0] OP_AREA_A = 8'h00;
  localparam logic [7:0] OP_AREA_B = 8'h01;
  localparam logic [7:0] OP_AREA_C = 8'h50;
  localparam logic [7:0] OP_RESET  = 8'hFF;
endpackage

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_rd_pkg::*;
#(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_p,
  input  logic [7:0]       din,
  output logic             start,
  output area_e            start_area,
  output logic [7:0]       start_col,
  output logic [ROW_W-1:0] start_row,
  output logic             reset_cmd,
  output area_e            ptr
);
  area_e       ptr_q, ptr_d;
  logic [1:0]  acnt_q, acnt_d;
  logic [7:0]  col_q, col_d;
  logic [7:0]  rlo_q, rlo_d;
  logic        cmd_v, adr_v, known_cmd;
  logic [15:0] row_full;

  assign cmd_v     = we_p & ~ce_n & cle & ~ale;
  assign adr_v     = we_p & ~ce_n & ale & ~cle;
  assign known_cmd = (din == OP_AREA_A) || (din == OP_AREA_B) ||
                     (din == OP_AREA_C) || (din == OP_RESET);
  assign start     = adr_v && (acnt_q == 2'd2);
  assign reset_cmd = cmd_v && (din == OP_RESET);
  assign row_full  = {din, rlo_q};
  assign start_row = row_full[ROW_W-1:0];
  assign start_col = col_q;
  assign start_area = ptr_q;
  assign ptr       = ptr_q;

  always_comb begin
    ptr_d  = ptr_q;
    acnt_d = acnt_q;
    col_d  = col_q;
    rlo_d  = rlo_q;
    if (cmd_v && known_cmd) begin
      acnt_d = 2'd0;
      case (din)
        OP_AREA_B: ptr_d = AREA_B;
        OP_AREA_C: ptr_d = AREA_C;
        default:   ptr_d = AREA_A;
      endcase
    end else if (adr_v) begin
      if (start) begin
        acnt_d = 2'd0;
        if (ptr_q == AREA_B) ptr_d = AREA_A;
      end else begin
        acnt_d = acnt_q + 2'd1;
      end
      if (acnt_q == 2'd0) col_d = din;
      if (acnt_q == 2'd1) rlo_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= AREA_A;
      acnt_q <= 2'd0;
      col_q  <= 8'd0;
      rlo_q  <= 8'd0;
    end else begin
      ptr_q  <= ptr_d;
      acnt_q <= acnt_d;
      col_q  <= col_d;
      rlo_q  <= rlo_d;
    end
  end
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int LOAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic abort,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(LOAD_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = CW'(LOAD_CYC);
    else if (abort) cnt_d = '0;
    else if (busy)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nand_ce_watch.sv
module nand_ce_watch #(
  parameter int CE_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic tmo
);
  localparam int CW = $clog2(CE_HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sat;

  assign sat = (cnt_q == CW'(CE_HOLD));
  assign tmo = ce_n && sat;

  always_comb begin
    if (!ce_n)    cnt_d = '0;
    else if (sat) cnt_d = cnt_q;
    else          cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nand_array_model.sv
module nand_array_model #(
  parameter int KW = 10
) (
  input  logic [KW-1:0] k,
  input  logic [7:0]    row_lo,
  output logic [7:0]    data
);
  logic [7:0] mixed;

  assign mixed = k[7:0] ^ {k[9:8], 6'b0};
  assign data  = mixed + row_lo;
endmodule

// File: rtl/nand_read_engine.sv
module nand_read_engine
  import nand_rd_pkg::*;
#(
  parameter int         MAIN_BYTES    = 512,
  parameter int         SPARE_BYTES   = 16,
  parameter int         PAGES_PER_BLK = 32,
  parameter int         ROW_W         = 16,
  parameter int         LOAD_CYC      = 8,
  parameter int         CE_HOLD       = 4,
  parameter logic [7:0] FILL          = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_p,
  input  logic [7:0] din,
  input  logic       re_p,
  output logic [7:0] dout,
  output logic       rdy
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int KW         = $clog2(PAGE_BYTES + 1);
  localparam int PBW        = $clog2(PAGES_PER_BLK);
  localparam int SPW        = $clog2(SPARE_BYTES);
  localparam int HALF       = MAIN_BYTES / 2;

  logic             start, reset_cmd, tmr_busy, tmr_last, tmo;
  area_e            sarea, ptr_cur;
  logic [7:0]       scol, arr_data;
  logic [ROW_W-1:0] srow;

  rd_state_e        st_q, st_d;
  logic [KW-1:0]    k_q, k_d, start_k, base_k;
  logic [ROW_W-1:0] row_q, row_d;
  area_e            area_q, area_d;
  logic [7:0]       dout_q, dout_d;
  logic             k_en, row_en, dout_en, tmr_load, tmr_abort, re_v, last_pg;

  nand_cmd_decoder #(.ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_p(we_p),
    .din(din), .start(start), .start_area(sarea), .start_col(scol),
    .start_row(srow), .reset_cmd(reset_cmd), .ptr(ptr_cur)
  );

  nand_busy_timer #(.LOAD_CYC(LOAD_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .abort(tmr_abort),
    .busy(tmr_busy), .last(tmr_last)
  );

  nand_ce_watch #(.CE_HOLD(CE_HOLD)) u_cew (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .tmo(tmo)
  );

  nand_array_model #(.KW(KW)) u_arr (
    .k(k_q), .row_lo(row_q[7:0]), .data(arr_data)
  );

  assign re_v    = re_p & ~ce_n;
  assign last_pg = (row_q[PBW-1:0] == {PBW{1'b1}});
  assign rdy     = ~tmr_busy;
  assign dout    = dout_q;

  always_comb begin
    case (sarea)
      AREA_B:  start_k = KW'(HALF) + KW'(scol);
      AREA_C:  start_k = KW'(MAIN_BYTES) + KW'(scol[SPW-1:0]);
      default: start_k = KW'(scol);
    endcase
    case (area_q)
      AREA_B:  base_k = KW'(HALF);
      AREA_C:  base_k = KW'(MAIN_BYTES);
      default: base_k = '0;
    endcase
  end

  always_comb begin
    st_d      = st_q;
    k_d       = k_q;
    row_d     = row_q;
    area_d    = area_q;
    dout_d    = dout_q;
    k_en      = 1'b0;
    row_en    = 1'b0;
    dout_en   = 1'b0;
    tmr_load  = 1'b0;
    tmr_abort = 1'b0;
    if (reset_cmd) begin
      st_d      = ST_IDLE;
      tmr_abort = 1'b1;
      if (re_v) begin dout_d = FILL; dout_en = 1'b1; end
    end else if (start) begin
      st_d     = ST_LOAD;
      k_d      = start_k;
      row_d    = srow;
      area_d   = sarea;
      k_en     = 1'b1;
      row_en   = 1'b1;
      tmr_load = 1'b1;
      if (re_v) begin dout_d = FILL; dout_en = 1'b1; end
    end else begin
      case (st_q)
        ST_LOAD: begin
          if (re_v) begin dout_d = FILL; dout_en = 1'b1; end
          if (tmo) begin
            st_d      = ST_IDLE;
            tmr_abort = 1'b1;
          end else if (tmr_last) begin
            st_d = ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (tmo) begin
            st_d = ST_IDLE;
          end else if (re_v) begin
            dout_en = 1'b1;
            if (k_q < KW'(PAGE_BYTES)) begin
              dout_d = arr_data;
              k_d    = k_q + KW'(1);
              k_en   = 1'b1;
            end else if (last_pg) begin
              dout_d = FILL;
              st_d   = ST_IDLE;
            end else begin
              dout_d   = FILL;
              row_d    = row_q + ROW_W'(1);
              row_en   = 1'b1;
              k_d      = base_k;
              k_en     = 1'b1;
              st_d     = ST_LOAD;
              tmr_load = 1'b1;
            end
          end
        end
        default: begin
          if (re_v) begin dout_d = FILL; dout_en = 1'b1; end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      row_q  <= '0;
      area_q <= AREA_A;
      dout_q <= FILL;
    end else begin
      st_q <= st_d;
      if (k_en)    k_q    <= k_d;
      if (row_en)  row_q  <= row_d;
      if (row_en)  area_q <= area_d;
      if (dout_en) dout_q <= dout_d;
    end
  end
endmodule

// File: rtl/nand_read_engine_chk.sv
module nand_read_engine_chk
  import nand_rd_pkg::*;
#(
  parameter int         KW   = 10,
  parameter logic [7:0] FILL = 8'h5A
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          cle,
  input logic          ale,
  input logic          we_p,
  input logic [7:0]    din,
  input logic          re_p,
  input logic [7:0]    dout,
  input logic          rdy,
  input area_e         ptr,
  input logic [KW-1:0] col
);
  assert_fill_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (re_p && !ce_n && !rdy) |=> (dout == FILL));

  assert_col_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (re_p && !ce_n && !rdy && !we_p) |=> $stable(col));

  assert_ce_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> $stable(dout));

  assert_reset_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we_p && !ce_n && cle && !ale && din == 8'hFF) |=> (ptr == AREA_A));

  assert_b_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdy) && $past(we_p && ale && !cle && !ce_n)) |-> (ptr != AREA_B));

  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(!ce_n && ((we_p && ale && !cle) || re_p)));
endmodule

bind nand_read_engine nand_read_engine_chk #(.KW(KW), .FILL(FILL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_p(we_p),
  .din(din), .re_p(re_p), .dout(dout), .rdy(rdy), .ptr(ptr_cur), .col(k_q)
);

// File: tb/nand_read_engine_test.sv
module nand_read_engine_test;
  localparam int         LOAD_CYC = 8;
  localparam int         CE_HOLD  = 4;
  localparam logic [7:0] FILL     = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_p = 1'b0, re_p = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       rdy;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  nand_read_engine uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_p(we_p),
    .din(din), .re_p(re_p), .dout(dout), .rdy(rdy)
  );

  function automatic logic [7:0] dexp(input logic [15:0] r, input int k);
    logic [9:0] kk;
    kk = 10'(k);
    return (kk[7:0] ^ {kk[9:8], 6'b0}) + r[7:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic we_cyc(input logic c, input logic a, input logic [7:0] d);
    cle = c; ale = a; din = d; we_p = 1'b1;
    @(negedge clk);
    we_p = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic re_cyc();
    re_p = 1'b1;
    @(negedge clk);
    re_p = 1'b0;
  endtask

  task automatic addr3(input logic [7:0] col, input logic [15:0] row);
    we_cyc(1'b0, 1'b1, col);
    we_cyc(1'b0, 1'b1, row[7:0]);
    we_cyc(1'b0, 1'b1, row[15:8]);
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 rdy", rdy, 1);
    check("R12 dout", dout, FILL);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 strobe with no read in progress
    re_cyc();
    check("R11 idle fill", dout, FILL);

    // R1/R5/R6 full page in area A, then R7 advance
    we_cyc(1'b1, 1'b0, 8'h00);
    addr3(8'd0, 16'h0040);
    check("R5 low at third addr", rdy, 0);
    wait_rdy(n);
    check("R5 busy length", n, LOAD_CYC);
    for (int k = 0; k < 528; k++) begin
      re_cyc();
      check("R6 page byte", dout, dexp(16'h0040, k));
    end
    re_cyc();
    check("R7 fill at page end", dout, FILL);
    check("R7 busy again", rdy, 0);
    wait_rdy(n);
    check("R7 busy length", n, LOAD_CYC);
    re_cyc();
    check("R7 next page first", dout, dexp(16'h0041, 0));

    // R8 block end on last page of block
    addr3(8'd250, 16'h005F);
    wait_rdy(n);
    for (int k = 250; k < 528; k++) begin
      re_cyc();
      check("R8 tail byte", dout, dexp(16'h005F, k));
    end
    re_cyc();
    check("R8 fill at block end", dout, FILL);
    check("R8 no reload", rdy, 1);
    re_cyc();
    check("R8 stays ended", dout, FILL);

    // R4/R2 spare area sweep, one command for all reads
    we_cyc(1'b1, 1'b0, 8'h50);
    for (int c = 0; c < 256; c++) begin
      addr3(8'(c), 16'h0123);
      wait_rdy(n);
      re_cyc();
      check("R4 R2 spare start", dout, dexp(16'h0123, 512 + (c % 16)));
    end
    // R7 in area C continues from spare base
    addr3(8'd14, 16'h0200);
    wait_rdy(n);
    re_cyc();
    check("R6 spare 526", dout, dexp(16'h0200, 526));
    re_cyc();
    check("R6 spare 527", dout, dexp(16'h0200, 527));
    re_cyc();
    check("R7 spare wrap fill", dout, FILL);
    wait_rdy(n);
    re_cyc();
    check("R7 spare next page", dout, dexp(16'h0201, 512));

    // R2/R4 area A persistence sweep
    we_cyc(1'b1, 1'b0, 8'h00);
    for (int c = 0; c < 256; c += 17) begin
      addr3(8'(c), 16'(c * 3 + 1));
      wait_rdy(n);
      re_cyc();
      check("R2 R4 area A start", dout, dexp(16'(c * 3 + 1), c));
      re_cyc();
      check("R6 area A second", dout, dexp(16'(c * 3 + 1), c + 1));
    end

    // R3/R4 area B one-shot
    for (int c = 0; c < 256; c += 51) begin
      we_cyc(1'b1, 1'b0, 8'h01);
      addr3(8'(c), 16'h0007);
      wait_rdy(n);
      re_cyc();
      check("R4 area B start", dout, dexp(16'h0007, 256 + c));
      addr3(8'(c), 16'h0007);
      wait_rdy(n);
      re_cyc();
      check("R3 back to area A", dout, dexp(16'h0007, c));
    end

    // R1 reset command returns pointer to A and ends a load
    we_cyc(1'b1, 1'b0, 8'h50);
    we_cyc(1'b1, 1'b0, 8'hFF);
    addr3(8'd3, 16'h0009);
    check("R1 load started", rdy, 0);
    we_cyc(1'b1, 1'b0, 8'hFF);
    check("R1 reset ends load", rdy, 1);
    re_cyc();
    check("R1 no stream after reset", dout, FILL);
    addr3(8'd3, 16'h0009);
    wait_rdy(n);
    re_cyc();
    check("R1 pointer A after reset", dout, dexp(16'h0009, 3));

    // R9/R10 chip enable handling
    addr3(8'd10, 16'h0030);
    wait_rdy(n);
    re_cyc();
    check("R6 k10", dout, dexp(16'h0030, 10));
    hold = dout;
    ce_n = 1'b1;
    re_cyc();
    check("R10 re ignored", dout, hold);
    we_cyc(1'b1, 1'b0, 8'hFF);
    @(negedge clk);
    ce_n = 1'b0;
    check("R10 reset ignored", rdy, 1);
    re_cyc();
    check("R10 R9 stream intact", dout, dexp(16'h0030, 11));
    ce_n = 1'b1;
    repeat (CE_HOLD) @(negedge clk);
    ce_n = 1'b0;
    re_cyc();
    check("R9 hold at limit", dout, dexp(16'h0030, 12));
    ce_n = 1'b1;
    repeat (CE_HOLD + 1) @(negedge clk);
    ce_n = 1'b0;
    re_cyc();
    check("R9 timeout ends read", dout, FILL);

    // R11/R5 strobe on the final busy edge and mid-busy
    addr3(8'd20, 16'h0066);
    check("R5 low after addr", rdy, 0);
    re_cyc();
    check("R11 mid-busy fill", dout, FILL);
    for (int j = 2; j < LOAD_CYC; j++) begin
      check("R5 still busy", rdy, 0);
      @(negedge clk);
    end
    re_cyc();
    check("R11 fill on last busy edge", dout, FILL);
    check("R5 ready after load", rdy, 1);
    re_cyc();
    check("R11 column unmoved", dout, dexp(16'h0066, 20));

    finish_run();
  end
endmodule